// File: doc/BRIEF.md
# Line 21 Caption Waveform Inserter

This block produces the digital bit stream for closed-caption data on one chosen video line of every field, inside a video encoder. Software loads four byte registers: a pair for the odd field (caption service) and a pair for the even field (extended data service). On the caption line of each field the block plays a clock run-in, then a three-bit start pattern, then the two bytes of that field's pair, least significant bit first. The output is a one-bit level `data_out` plus a strobe `data_valid` that marks each new half-bit slot. Analog shaping and mixing into luminance happen downstream.

Timing comes from two external pulses, `line_start` and `field_start`, and a field parity level. Bits last 1/32 of a line. Because the clocks per line are not a multiple of the bit count, a fractional phase accumulator places half-bit boundaries. The block never computes parity. Bit 7 of every byte goes out exactly as written. Writes are staged and only reach the transmit buffer at the next start of a field of matching parity. A pair that has not been rewritten since its last load goes out as the null byte 0x80 twice.

Top module: `cc_line_inserter`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in one of four byte registers. `wr_addr[1]` picks the pair (0 odd, 1 even) and `wr_addr[0]` picks the byte (0 first, 1 second).
- R2: `field_odd` is sampled on the `field_start` cycle. An odd field transmits the odd pair and an even field transmits the even pair.
- R3: On the caption line the half-slot sequence is fixed. First come 14 half-slots alternating 1,0 starting with 1. Next come framing bits 0,0,1, each lasting two half-slots. Last come 16 data bits, each lasting two half-slots: the first byte bit 0 to bit 7, then the second byte bit 0 to bit 7.
- R4: Bit 7 of each byte is transmitted as written, with no parity generated or corrected.
- R5: A line has SLOTS_PER_LINE=64 half-slots. Boundaries are set by an accumulator that adds 64 per clock modulo CLK_PER_LINE and restarts at `line_start`. The window begins at half-slot START_HALF and carries exactly 52 `data_valid` strobes. Consecutive strobes are between floor and ceil of CLK_PER_LINE/64 clocks apart.
- R6: Lines are numbered from 1 at `field_start`. Only line CAPTION_LINE carries the window. Everywhere else `data_out` and `data_valid` stay 0.
- R7: A write loads only a staging copy. That copy reaches the transmit buffer at the next `field_start` of matching parity, so a write made during a transmission never changes the bytes being sent.
- R8: At the start of a field, a pair with no write since its previous load sends 0x80 in both bytes. A pair with only one byte written sends 0x80 in the other byte.
- R9: While `rst_n` is low, `data_out` and `data_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | One-clock pulse on the first clock of each line |
| field_start | input | 1 | One-clock pulse, together with `line_start`, on line 1 of a field |
| field_odd | input | 1 | Field parity, sampled with `field_start` (1 = odd) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select: bit 1 pair, bit 0 byte |
| wr_data | input | 8 | Byte to write |
| data_out | output | 1 | Caption waveform level, 0 outside the window |
| data_valid | output | 1 | Pulse at the start of each half-slot in the window |

## Verification
For each half-slot, `data_out` and `data_valid` change at the same clock edge that starts that half-slot. They therefore become visible in the cycle right after the edge that samples `line_start` or that marks an accumulator wrap. The monitor samples on the falling edge and pops one expected level from the scoreboard for every strobe it sees. A write becomes visible only on the caption line of the next field of matching parity. The driver therefore fills the expected queue from its own staging model at the `field_start` cycle, before that line begins. Blank checks start in the cycle after each line-start edge, and the per-line strobe count and empty-queue checks are made at the edge that opens the following line.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int RUNIN_HALVES  = 14;
   localparam int FRAME_BITS    = 3;
   localparam int DATA_BITS     = 16;
   localparam int WINDOW_HALVES = RUNIN_HALVES + 2 * (FRAME_BITS + DATA_BITS);
   localparam logic [7:0] NULL_BYTE = 8'h80;

   typedef struct packed {
      logic [7:0] second;
      logic [7:0] first;
   } cc_pair_t;

   localparam cc_pair_t NULL_PAIR = '{second: NULL_BYTE, first: NULL_BYTE};
endpackage

// File: rtl/cc_half_clock.sv
module cc_half_clock #(
   parameter int CLK_PER_LINE = 1716,
   parameter int SLOTS        = 64,
   parameter int SLOT_W       = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   output logic              slot_step,
   output logic [SLOT_W-1:0] slot_next
);
   localparam int ACC_W   = $clog2(CLK_PER_LINE + SLOTS) + 1;
   localparam int MAX_GAP = (CLK_PER_LINE + SLOTS - 1) / SLOTS;
   localparam int MIN_GAP = CLK_PER_LINE / SLOTS;
   localparam int GAP_W   = $clog2(MAX_GAP + 2) + 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic [ACC_W-1:0]  acc, acc_sum;
   logic [SLOT_W-1:0] slot;
   logic              wrap;

   always_comb begin
      acc_sum = acc + ACC_W'(SLOTS);
      wrap    = !line_start && (acc_sum >= ACC_W'(CLK_PER_LINE));
   end

   always_comb begin
      slot_step = line_start || (wrap && slot != LAST_SLOT);
      if (line_start)
         slot_next = '0;
      else if (wrap && slot != LAST_SLOT)
         slot_next = slot + 1'b1;
      else
         slot_next = slot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         slot <= '0;
      end else begin
         slot <= slot_next;
         if (line_start)
            acc <= '0;
         else if (wrap)
            acc <= acc_sum - ACC_W'(CLK_PER_LINE);
         else
            acc <= acc_sum;
      end
   end

   // clocks since the last half-slot boundary, for the spacing check
   logic [GAP_W-1:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap <= GAP_W'(1);
      else if (slot_step)
         gap <= GAP_W'(1);
      else if (gap != '1)
         gap <= gap + 1'b1;
   end

   a_r5_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !line_start && slot != LAST_SLOT) |->
         (gap <= GAP_W'(MAX_GAP) && gap >= GAP_W'(MIN_GAP)));
endmodule

// File: rtl/cc_line_track.sv
module cc_line_track #(
   parameter int CAPTION_LINE = 21,
   parameter int LINE_W       = $clog2(CAPTION_LINE + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic field_start,
   output logic caption_next,
   output logic caption_now
);
   logic [LINE_W-1:0] line_no, line_no_next;

   always_comb begin
      if (field_start)
         line_no_next = LINE_W'(1);
      else if (line_start && line_no != '1)
         line_no_next = line_no + 1'b1;
      else
         line_no_next = line_no;
      caption_next = (line_no_next == LINE_W'(CAPTION_LINE));
      caption_now  = (line_no == LINE_W'(CAPTION_LINE));
   end

   // saturated count until the first field start: no caption line yet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_no <= '1;
      else
         line_no <= line_no_next;
   end

   a_r6_field_restart: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> (line_no == LINE_W'(1)));
endmodule

// File: rtl/cc_field_regs.sv
module cc_field_regs
   import cc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       field_start,
   input  logic       field_odd,
   output cc_pair_t   active
);
   cc_pair_t [1:0] staged_v;
   logic     [1:0] pend_v;
   logic           sel_idx;

   assign sel_idx = field_odd ? 1'b0 : 1'b1;

   for (genvar f = 0; f < 2; f++) begin : g_pair
      cc_pair_t stg;
      logic     pend;
      logic     load_here;
      assign load_here = field_start && (sel_idx == 1'(f));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg  <= NULL_PAIR;
            pend <= 1'b0;
         end else begin
            if (load_here) begin
               stg  <= NULL_PAIR;
               pend <= 1'b0;
            end
            if (wr_en && wr_addr[1] == 1'(f)) begin
               if (wr_addr[0]) stg.second <= wr_data;
               else            stg.first  <= wr_data;
               pend <= 1'b1;
            end
         end
      end
      assign staged_v[f] = stg;
      assign pend_v[f]   = pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active <= NULL_PAIR;
      else if (field_start)
         active <= pend_v[sel_idx] ? staged_v[sel_idx] : NULL_PAIR;
   end

   a_r8_null_load: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && !pend_v[sel_idx]) |=> (active == NULL_PAIR));
   a_r7_no_tear: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(active));
endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
   import cc_pkg::*;
#(
   parameter int START_HALF = 4,
   parameter int SLOT_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_step,
   input  logic [SLOT_W-1:0] slot_next,
   input  logic              caption_next,
   input  cc_pair_t          pair,
   output logic              data_out,
   output logic              data_valid
);
   function automatic logic level_at(input int k, input cc_pair_t p);
      logic [DATA_BITS-1:0] v;
      v = p;
      if (k < RUNIN_HALVES)
         return (k % 2) == 0;
      else if (k < RUNIN_HALVES + 2 * FRAME_BITS)
         return ((k - RUNIN_HALVES) / 2) == FRAME_BITS - 1;
      else
         return v[4'((k - RUNIN_HALVES - 2 * FRAME_BITS) / 2)];
   endfunction

   int   k;
   logic in_win;
   logic lvl;

   always_comb begin
      k      = int'(slot_next) - START_HALF;
      in_win = caption_next && (k >= 0) && (k < WINDOW_HALVES);
      lvl    = in_win ? level_at(k, pair) : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out   <= 1'b0;
         data_valid <= 1'b0;
      end else begin
         data_valid <= slot_step && in_win;
         if (slot_step)
            data_out <= lvl;
      end
   end
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
   import cc_pkg::*;
#(
   parameter int CLK_PER_LINE   = 1716,
   parameter int SLOTS_PER_LINE = 64,
   parameter int CAPTION_LINE   = 21,
   parameter int START_HALF     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_start,
   input  logic       field_start,
   input  logic       field_odd,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       data_out,
   output logic       data_valid
);
   localparam int SLOT_W = $clog2(SLOTS_PER_LINE);

   if (CAPTION_LINE < 2) begin : g_bad_line
      $error("CAPTION_LINE must be at least 2");
   end
   if (START_HALF + WINDOW_HALVES > SLOTS_PER_LINE) begin : g_bad_start
      $error("caption window does not fit in the line");
   end
   if (CLK_PER_LINE < SLOTS_PER_LINE) begin : g_bad_rate
      $error("CLK_PER_LINE must not be below SLOTS_PER_LINE");
   end

   logic              slot_step;
   logic [SLOT_W-1:0] slot_next;
   logic              caption_next, caption_now;
   cc_pair_t          active;

   cc_half_clock #(
      .CLK_PER_LINE (CLK_PER_LINE),
      .SLOTS        (SLOTS_PER_LINE),
      .SLOT_W       (SLOT_W)
   ) i_clock (
      .clk, .rst_n, .line_start, .slot_step, .slot_next
   );

   cc_line_track #(
      .CAPTION_LINE (CAPTION_LINE)
   ) i_track (
      .clk, .rst_n, .line_start, .field_start, .caption_next, .caption_now
   );

   cc_field_regs i_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .field_start, .field_odd, .active
   );

   cc_serializer #(
      .START_HALF (START_HALF),
      .SLOT_W     (SLOT_W)
   ) i_ser (
      .clk, .rst_n, .slot_step, .slot_next, .caption_next,
      .pair (active), .data_out, .data_valid
   );

   a_r6_valid_on_caption: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> caption_now);
   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!data_out && !data_valid));
endmodule

// File: tb/test_cc_line_inserter.sv
module test_cc_line_inserter;
   localparam int CPL   = 100;
   localparam int CAP   = 3;
   localparam int START = 4;
   localparam int LINES = 5;
   localparam int WIN   = 52;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0, field_start = 1'b0, field_odd = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       data_out, data_valid;

   always #5 clk = ~clk;

   cc_line_inserter #(
      .CLK_PER_LINE (CPL), .SLOTS_PER_LINE (64),
      .CAPTION_LINE (CAP), .START_HALF (START)
   ) i_cc_line_inserter (
      .clk, .rst_n, .line_start, .field_start, .field_odd,
      .wr_en, .wr_addr, .wr_data, .data_out, .data_valid
   );

   int     checks = 0, errors = 0;
   bit     mon_on = 0, in_cap = 0, prev_cap = 0, done = 0;
   int     strobes = 0;
   longint cyc = 0, last_cyc = 0;
   string  tag = "R3";
   logic   exp_q[$];

   logic [7:0] m_stg [4];
   bit         m_pend [2];
   bit         pw_v [0:LINES];
   logic [1:0] pw_a [0:LINES];
   logic [7:0] pw_d [0:LINES];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops one expected level per strobe
   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (data_valid) begin
            if (strobes > 0)
               chk(cyc - last_cyc >= 1 && cyc - last_cyc <= 2, "R5 strobe spacing",
                   int'(cyc - last_cyc), 2);
            last_cyc = cyc;
            strobes++;
            if (exp_q.size() == 0)
               chk(1'b0, "R3 unexpected strobe", 1, 0);
            else
               chk(data_out === exp_q[0], tag, int'(data_out), int'(exp_q[0]));
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
         if (!in_cap)
            chk(data_out === 1'b0 && data_valid === 1'b0, "R6 blank off caption line",
                int'({data_valid, data_out}), 0);
      end
   end

   task automatic push_expected(input logic [7:0] first, input logic [7:0] second);
      logic [15:0] v;
      v = {second, first};
      for (int k = 0; k < 14; k++) exp_q.push_back(k % 2 == 0);
      for (int f = 0; f < 3; f++) begin
         exp_q.push_back(f == 2);
         exp_q.push_back(f == 2);
      end
      for (int d = 0; d < 16; d++) begin
         exp_q.push_back(v[d]);
         exp_q.push_back(v[d]);
      end
   endtask

   logic [7:0] cur_first = 8'h80, cur_second = 8'h80;

   task automatic run_line(input bit fs, input bit odd, input int ln);
      for (int c = 0; c < CPL; c++) begin
         line_start  = (c == 0);
         field_start = (c == 0) && fs;
         field_odd   = odd;
         wr_en       = (c == 50) && pw_v[ln];
         wr_addr     = pw_a[ln];
         wr_data     = pw_d[ln];
         if (c == 0 && fs) begin
            int p;
            p = odd ? 0 : 1;
            if (m_pend[p]) begin
               cur_first  = m_stg[2*p];
               cur_second = m_stg[2*p+1];
            end else begin
               cur_first  = 8'h80;
               cur_second = 8'h80;
            end
            m_stg[2*p]   = 8'h80;
            m_stg[2*p+1] = 8'h80;
            m_pend[p]    = 1'b0;
         end
         if (c == 0 && ln == CAP) push_expected(cur_first, cur_second);
         @(posedge clk);
         #1;
         if (wr_en) begin
            m_stg[wr_addr] = wr_data;
            m_pend[wr_addr[1]] = 1'b1;
         end
         if (c == 0) begin
            if (prev_cap) begin
               chk(strobes == WIN, "R5 strobes per caption line", strobes, WIN);
               chk(exp_q.size() == 0, "R3 sequence complete", exp_q.size(), 0);
               exp_q.delete();
            end
            strobes  = 0;
            in_cap   = (ln == CAP);
            prev_cap = in_cap;
         end
      end
      line_start = 0; field_start = 0; wr_en = 0;
   endtask

   task automatic plan_wr(input int ln, input logic [1:0] a, input logic [7:0] d);
      pw_v[ln] = 1'b1; pw_a[ln] = a; pw_d[ln] = d;
   endtask

   task automatic run_field(input bit odd, input string t);
      tag = t;
      for (int ln = 1; ln <= LINES; ln++) run_line(ln == 1, odd, ln);
      for (int ln = 0; ln <= LINES; ln++) pw_v[ln] = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 4; i++) m_stg[i] = 8'h80;
      m_pend[0] = 0; m_pend[1] = 0;
      for (int ln = 0; ln <= LINES; ln++) begin
         pw_v[ln] = 0; pw_a[ln] = '0; pw_d[ln] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(data_out === 1'b0 && data_valid === 1'b0, "R9 reset outputs",
          int'({data_valid, data_out}), 0);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      mon_on = 1;
      // R1 R6: writes on lines before any field start, output stays blank
      plan_wr(0, 2'd0, 8'h14); run_line(0, 0, 0);
      plan_wr(0, 2'd1, 8'hAB); run_line(0, 0, 0);
      pw_v[0] = 0;
      run_field(1, "R1 R2 R3 odd pair 14 AB");
      run_field(0, "R8 even null pair");
      // R7: writes during and after the caption line of this field
      plan_wr(3, 2'd0, 8'h55);
      plan_wr(4, 2'd1, 8'h02);
      plan_wr(5, 2'd2, 8'h9E);
      run_field(1, "R7 R8 odd resend null while new data staged");
      plan_wr(4, 2'd2, 8'h00);
      plan_wr(5, 2'd3, 8'hFF);
      run_field(0, "R8 even single byte 9E with null");
      run_field(1, "R7 R4 odd staged 55 02 as written");
      run_field(0, "R2 R4 even 00 FF bit7 set");
      run_field(1, "R8 odd null again");
      run_line(0, 1, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule